// File: doc/BRIEF.md
# Request/Wait Memory Responder

This block is the memory side of a simple read/write bus. The master raises `req` together with a read/write select, an address and, for writes, the data. A transfer whose latency fits inside a fixed access window completes with no acknowledge of any kind: the read word simply shows up on the bus in time. A transfer that needs longer raises `waitOut` early. The responder then drops `waitOut` on the same clock edge that makes the read word valid or commits the write into storage.

After the data phase, the responder holds its bus state until the master lowers `req`. Only then does it release the data lines and return to accepting requests. The latency of each request comes from an input, so a system model or a test can choose either the fast or the slow path for each transfer. Storage is a small register array that is cleared by reset.

Top module: `reqwait_mem_responder`

## Requirements
- R1: While reset is active, and immediately after it, `waitOut` is 0, `busValid` is 0 and `busData` is all zeros.
- R2: A request is captured on the first rising clock edge at which the responder is idle and `req` is 1. The effective latency E is `latency`, or 1 when `latency` is 0. When E <= TACCESS, `waitOut` stays 0 for the whole transfer.
- R3: When E > TACCESS, `waitOut` is 1 from the capture edge onward and stays 1 until the completion edge. It is therefore high well before the access window ends.
- R4: The completion edge is the E-th rising edge after the capture edge. For a read (`rdWrN` = 0), `busData` carries the stored word and `busValid` is 1 from that edge onward. `waitOut` is never 1 while `busValid` is 1.
- R5: For a write (`rdWrN` = 1), the captured data is written into the captured address at the completion edge. A later read of that address returns it.
- R6: `rdWrN`, `addr`, `wrData` and `latency` are sampled only at the capture edge. Changes to them during the transfer have no effect on the result.
- R7: After completion the responder holds `busData`, `busValid` and `waitOut` unchanged, and accepts no new request, as long as `req` stays 1.
- R8: A `latency` of 0 behaves exactly like a `latency` of 1.
- R9: The data lines are released whenever no read is presenting data: `busValid` is 0 and `busData` is zero. A write never sets `busValid`. The release takes effect on the first rising edge after completion at which `req` is sampled 0.
- R10: Every storage word reads as zero after reset, including after a reset applied in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request from the master |
| rdWrN | input | 1 | Direction: 0 = read, 1 = write |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data |
| latency | input | LAT_W | Cycles from capture to completion for this request |
| waitOut | output | 1 | Stretches slow transfers; falling edge marks data ready or latched |
| busData | output | DATA_W | Read data, zero when released |
| busValid | output | 1 | High while the responder drives read data |

## Verification
The bench sits on both sides of the window boundary: latency equal to TACCESS and latency of TACCESS+1. A design with an off-by-one in the window compare would raise `waitOut` on a fast access or stay silent on a slow one. A zero latency is sent to catch a counter that underflows and hangs the transfer. Address and write data are changed mid-transfer, and the address is changed again during the hold phase, to expose a responder that samples late or starts a second access before `req` drops. A reset in the middle of a slow write checks that the outputs are released, that the write never lands, and that storage reads back as zero.

// File: rtl/reqwait_pkg.sv
package reqwait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } rwState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch direction, address and write data
    logic complete;  // perform the storage access now
    logic relBus;    // stop driving the data lines
  } rwStrobe_t;

endpackage

// File: rtl/reqwait_ctrl.sv
module reqwait_ctrl
  import reqwait_pkg::*;
#(
  parameter int LAT_W   = 4,
  parameter int TACCESS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             req,
  input  logic [LAT_W-1:0] latency,
  output rwStrobe_t        strobe,
  output logic             waitOut
);

  localparam logic [LAT_W-1:0] WINDOW = LAT_W'(TACCESS);
  localparam logic [LAT_W-1:0] ONE    = LAT_W'(1);

  rwState_e         state;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] effLat;
  logic             slowReq;
  logic             waitQ;

  // a zero latency is promoted to one cycle
  assign effLat  = (latency == '0) ? ONE : latency;
  assign slowReq = effLat > WINDOW;

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && req;
    strobe.complete = (state == ST_BUSY) && (cnt == ONE);
    strobe.relBus   = (state == ST_HOLD) && !req;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      waitQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strobe.capture) begin
            cnt   <= effLat;
            waitQ <= slowReq;
            state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (strobe.complete) begin
            waitQ <= 1'b0;
            cnt   <= '0;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        ST_HOLD: begin
          if (strobe.relBus) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign waitOut = waitQ;

endmodule

// File: rtl/reqwait_datapath.sv
module reqwait_datapath
  import reqwait_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rwStrobe_t         strobe,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] busData,
  output logic              busValid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic              isWrQ;
  logic [DATA_W-1:0] wdQ;
  logic [DATA_W-1:0] rdQ;
  logic              driveQ;
  logic [DATA_W-1:0] store [DEPTH];

  // request registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      isWrQ <= 1'b0;
      wdQ   <= '0;
    end else if (strobe.capture) begin
      addrQ <= addr;
      isWrQ <= rdWrN;
      wdQ   <= wrData;
    end
  end

  // storage array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (strobe.complete && isWrQ) begin
      store[addrQ] <= wdQ;
    end
  end

  // read register and bus driver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ    <= '0;
      driveQ <= 1'b0;
    end else if (strobe.complete && !isWrQ) begin
      rdQ    <= store[addrQ];
      driveQ <= 1'b1;
    end else if (strobe.relBus) begin
      rdQ    <= '0;
      driveQ <= 1'b0;
    end
  end

  assign busData  = driveQ ? rdQ : '0;
  assign busValid = driveQ;

endmodule

// File: rtl/reqwait_mem_responder.sv
module reqwait_mem_responder
  import reqwait_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int LAT_W   = 4,
  parameter int TACCESS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              rdWrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LAT_W-1:0]  latency,
  output logic              waitOut,
  output logic [DATA_W-1:0] busData,
  output logic              busValid
);

  rwStrobe_t strobe;

  reqwait_ctrl #(
    .LAT_W  (LAT_W),
    .TACCESS(TACCESS)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .latency(latency),
    .strobe (strobe),
    .waitOut(waitOut)
  );

  reqwait_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdWrN   (rdWrN),
    .addr    (addr),
    .wrData  (wrData),
    .busData (busData),
    .busValid(busValid)
  );

endmodule

// File: rtl/reqwait_mem_responder_chk.sv
module reqwait_mem_responder_chk #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int LAT_W   = 4,
  parameter int TACCESS = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              rdWrN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [LAT_W-1:0]  latency,
  input logic              waitOut,
  input logic [DATA_W-1:0] busData,
  input logic              busValid
);

  localparam logic [LAT_W-1:0] WINDOW = LAT_W'(TACCESS);

  // R9: released lines read as zero
  a_r9_bus_released: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (busData == '0));

  // R4: stretch and data phase never overlap
  a_r4_no_wait_with_data: assert property (@(posedge clk) disable iff (!rstN)
    waitOut |-> !busValid);

  // R7: presented data is held while the master keeps req high
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && req) |=> (busValid && $stable(busData)));

  // R3: the stretch starts only from a captured request
  a_r3_wait_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitOut) |-> $past(req));

  // R2: a request inside the window never stretches
  a_r2_fast_never_waits: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitOut) |-> ($past(latency) > WINDOW));

endmodule

bind reqwait_mem_responder reqwait_mem_responder_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LAT_W  (LAT_W),
  .TACCESS(TACCESS)
) chk_i (.*);

// File: tb/reqwait_mem_responder_tb_top.sv
`timescale 1ns/1ps
module reqwait_mem_responder_tb_top;

  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int LAT_W   = 4;
  localparam int TACCESS = 3;
  localparam int NVEC    = 10;

  // vector: [16] write, [15:12] addr, [11:4] data, [3:0] latency
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 4'h3, 8'h5A, 4'd1},
    {1'b0, 4'h3, 8'h00, 4'd2},
    {1'b1, 4'h7, 8'hC3, 4'd5},
    {1'b0, 4'h7, 8'h00, 4'd6},
    {1'b0, 4'h0, 8'h00, 4'd3},
    {1'b0, 4'h3, 8'h00, 4'd4},
    {1'b1, 4'hF, 8'h99, 4'd0},
    {1'b0, 4'hF, 8'h00, 4'd0},
    {1'b1, 4'h3, 8'h11, 4'd3},
    {1'b0, 4'h3, 8'h00, 4'd9}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              req;
  logic              rdWrN;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wrData;
  logic [LAT_W-1:0]  latency;
  logic              waitOut;
  logic [DATA_W-1:0] busData;
  logic              busValid;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] model [1 << ADDR_W];

  always #5 clk = ~clk;

  reqwait_mem_responder #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W), .TACCESS(TACCESS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .req(req), .rdWrN(rdWrN), .addr(addr),
    .wrData(wrData), .latency(latency), .waitOut(waitOut),
    .busData(busData), .busValid(busValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
  endtask

  // called at a negedge with the responder idle; returns at a negedge, idle again
  task automatic runAccess(input logic wr, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, input logic [LAT_W-1:0] lat,
                           input bit skew);
    int  e;
    bit  slow;
    logic [DATA_W-1:0] expRd;
    e     = (lat == 0) ? 1 : int'(lat);
    slow  = (e > TACCESS);
    expRd = model[a];
    req = 1'b1; rdWrN = wr; addr = a; wrData = d; latency = lat;
    for (int k = 0; k < e; k++) begin
      @(negedge clk);
      check(slow ? "R3 wait held during slow access" : "R2 no wait on fast access",
            32'(waitOut), 32'(slow));
      check("R4 no data before completion", 32'(busValid), 32'd0);
      if (skew && k == 0) begin
        addr = ~a; wrData = ~d; rdWrN = ~wr; latency = 4'd1;
      end
    end
    @(negedge clk);
    check("R4 wait low at completion", 32'(waitOut), 32'd0);
    if (wr) begin
      check("R9 write never drives bus", 32'(busValid), 32'd0);
      check("R9 write leaves data zero", 32'(busData), 32'd0);
      model[a] = d;
    end else begin
      check("R4 valid at completion edge", 32'(busValid), 32'd1);
      check(lat == 0 ? "R8 zero latency read data" : "R4 read data", 32'(busData), 32'(expRd));
    end
    addr = a + 1'b1;
    @(negedge clk);
    check("R7 held while req high", 32'(busValid), 32'(!wr));
    check("R7 data stable while req high", 32'(busData), wr ? 32'd0 : 32'(expRd));
    check("R7 no new access while req high", 32'(waitOut), 32'd0);
    req = 1'b0;
    @(negedge clk);
    check("R9 released after req drop", 32'(busValid), 32'd0);
    check("R9 data zero after release", 32'(busData), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; req = 1'b0; rdWrN = 1'b0; addr = '0; wrData = '0; latency = '0;
    clearModel();
    repeat (3) @(negedge clk);
    check("R1 wait low in reset", 32'(waitOut), 32'd0);
    check("R1 valid low in reset", 32'(busValid), 32'd0);
    check("R1 data zero in reset", 32'(busData), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 wait low after reset", 32'(waitOut), 32'd0);
    check("R1 valid low after reset", 32'(busValid), 32'd0);

    // R10: fresh storage reads zero
    runAccess(1'b0, 4'h5, 8'h00, 4'd2, 1'b0);

    // vector table: R2 R3 R4 R5 R8 boundaries
    for (int v = 0; v < NVEC; v++) begin
      runAccess(VEC[v][16], VEC[v][15:12], VEC[v][11:4], VEC[v][3:0], 1'b0);
    end

    // R6: inputs changed after capture are ignored
    runAccess(1'b1, 4'h2, 8'hAA, 4'd4, 1'b1);
    runAccess(1'b0, 4'h2, 8'h00, 4'd1, 1'b0);
    check("R6 late write data ignored", 32'(model[2]), 32'hAA);
    runAccess(1'b0, 4'hD, 8'h00, 4'd2, 1'b0);
    runAccess(1'b0, 4'h2, 8'h00, 4'd5, 1'b1);

    // R10: reset in the middle of a slow write
    req = 1'b1; rdWrN = 1'b1; addr = 4'h6; wrData = 8'h77; latency = 4'd8;
    repeat (3) @(negedge clk);
    check("R3 wait high before mid reset", 32'(waitOut), 32'd1);
    rstN = 1'b0; req = 1'b0;
    @(negedge clk);
    check("R1 wait cleared by reset", 32'(waitOut), 32'd0);
    check("R1 valid cleared by reset", 32'(busValid), 32'd0);
    rstN = 1'b1;
    clearModel();
    @(negedge clk);
    runAccess(1'b0, 4'h6, 8'h00, 4'd1, 1'b0);
    runAccess(1'b0, 4'h3, 8'h00, 4'd4, 1'b0);
    check("R10 model cleared", 32'(model[3]), 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule